// File: doc/BRIEF.md
# Frame Alignment Evaluation Unit

This block measures how late a frame evaluation signal arrives relative to the frame pulse. It counts the lag in steps of half a master-clock period. Both inputs are sampled on the rising and the falling clock edge, so a lag of any whole number of half periods can be resolved without a faster clock. A format select picks the edge polarity used as the reference. In one format the falling edges of both signals are compared, and in the other the rising edges are compared.

Host software drives the measurement through one start bit. The start bit must first stay low for a whole frame, and its rising edge then arms a capture. The first reference edge after that opens the measured frame, and the next reference edge closes it. When the frame closes, a 12-bit result is published together with a completion flag. Both are held until the start bit is cleared. Another measurement needs the same low-then-high sequence again.

Top module: `fa_align_eval`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: A rising edge of `start_i` starts a measurement only if `start_i` stayed low while two reference edges of the frame pulse were sampled, which is one complete frame. Otherwise the rising edge is ignored and `done_o` stays 0.
- R3: After a valid start, the first reference edge opens the measured frame and the next reference edge closes it. `done_o` rises two clock cycles after the cycle in whose half-samples the closing edge lies.
- R4: With `rise_fmt_i` = 0, the reference edges are falling edges of `frame_pulse_i`, and the measured edges are falling edges of `eval_i`.
- R5: With `rise_fmt_i` = 1, the reference edges are rising edges of `frame_pulse_i`, and the measured edges are rising edges of `eval_i`.
- R6: `result_o` is the number of half clock periods from the opening reference edge to the first evaluation edge at or after it, within the measured frame. An edge in the same half-sample gives 0, and odd values occur.
- R7: The count saturates at 4095. If the measured frame closes with no evaluation edge, `result_o` is 4095.
- R8: While `start_i` stays high, `done_o` stays 1 and `result_o` stays stable. Clearing `start_i` drops `done_o`. `result_o` keeps its value and changes only when `done_o` rises.
- R9: Clearing `start_i` before completion abandons the measurement without raising `done_o`.
- R10: After a measurement completes or is abandoned, a new rising edge of `start_i` is ignored unless `start_i` has again been low for one complete frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; inputs sampled on both edges |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse_i | input | 1 | Frame pulse; its selected edge marks frame start |
| eval_i | input | 1 | Frame evaluation signal whose lag is measured |
| rise_fmt_i | input | 1 | 0: compare falling edges, 1: compare rising edges |
| start_i | input | 1 | Host start bit |
| result_o | output | 12 | Measured lag in half clock periods |
| done_o | output | 1 | Measurement complete flag |

## Verification
Two functions can land in the same cycle. The first pair is the reference edge that opens the frame and the evaluation edge. The lag is zero when both fall in one half-sample, and an odd lag splits the two edges across the two halves of one clock. The second pair is an edge arriving in the same cycle as a change of the start bit, which matters for arming and for abandoning a measurement. The bench provokes the coincident cases with evaluation offsets of 0, 1, 7 and 15 half periods, and it drops the start bit in the middle of a measured frame. A behavioural half-step model predicts `done_o` and `result_o` for every clock, and each scenario also compares against its fixed expected lag.

// File: rtl/fa_eval_pkg.sv
package fa_eval_pkg;

    localparam int RES_W   = 12;
    localparam int HALVES  = 2;
    localparam int ARM_W   = 2;
    localparam logic [ARM_W-1:0] ARM_FULL = 2'd2;

    typedef enum logic [1:0] {
        FA_IDLE = 2'd0,
        FA_SYNC = 2'd1,
        FA_MEAS = 2'd2,
        FA_DONE = 2'd3
    } fa_state_e;

    typedef struct packed {
        logic ref_e;
        logic ev_e;
    } fa_half_s;

    function automatic logic edge_hit(input logic prev, input logic cur, input logic rise);
        return rise ? (!prev && cur) : (prev && !cur);
    endfunction

endpackage

// File: rtl/fa_dual_sampler.sv
module fa_dual_sampler #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] prev_q,
    output logic [W-1:0] h0_q,
    output logic [W-1:0] h1_q
);
    logic [W-1:0] neg_q;

    // mid-cycle sample
    always_ff @(negedge clk) begin
        neg_q <= din;
    end

    // align both halves of one clock period into the rising-edge domain
    always_ff @(posedge clk) begin
        h0_q   <= neg_q;
        h1_q   <= din;
        prev_q <= h1_q;
    end

endmodule

// File: rtl/fa_edge_find.sv
module fa_edge_find
    import fa_eval_pkg::*;
(
    input  logic                   rise,
    input  logic [1:0]             prev_s,
    input  logic [1:0]             h0_s,
    input  logic [1:0]             h1_s,
    output fa_half_s [HALVES-1:0]  halves
);
    // bit 0 is the frame pulse, bit 1 the evaluation input
    logic [1:0] seq [HALVES+1];

    assign seq[0] = prev_s;
    assign seq[1] = h0_s;
    assign seq[2] = h1_s;

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        assign halves[g].ref_e = edge_hit(seq[g][0], seq[g+1][0], rise);
        assign halves[g].ev_e  = edge_hit(seq[g][1], seq[g+1][1], rise);
    end

endmodule

// File: rtl/fa_meas_core.sv
module fa_meas_core
    import fa_eval_pkg::*;
#(
    parameter int RW = RES_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  fa_half_s [HALVES-1:0] halves,
    input  logic                  start_s,
    output logic [RW-1:0]         result_o,
    output logic                  done_o
);
    localparam logic [RW-1:0] CNT_MAX = {RW{1'b1}};

    fa_state_e        st_q, st_n;
    logic [ARM_W-1:0] arm_q, arm_n;
    logic [RW-1:0]    cnt_q, cnt_n;
    logic [RW-1:0]    cap_q, cap_n;
    logic [RW-1:0]    res_q, res_n;
    logic             got_q, got_n;
    logic             start_p;

    always_comb begin
        st_n  = st_q;
        arm_n = arm_q;
        cnt_n = cnt_q;
        cap_n = cap_q;
        res_n = res_q;
        got_n = got_q;
        if (st_q == FA_IDLE) begin
            if (start_s) begin
                arm_n = '0;
            end else begin
                for (int h = 0; h < HALVES; h++) begin
                    if (halves[h].ref_e && arm_n != ARM_FULL) begin
                        arm_n = arm_n + 1'b1;
                    end
                end
            end
            if (start_s && !start_p && arm_q == ARM_FULL) begin
                st_n  = FA_SYNC;
                got_n = 1'b0;
                cnt_n = '0;
            end
        end else if (!start_s) begin
            st_n  = FA_IDLE;
            arm_n = '0;
        end else begin
            for (int h = 0; h < HALVES; h++) begin
                case (st_n)
                    FA_SYNC: begin
                        if (halves[h].ref_e) begin
                            st_n  = FA_MEAS;
                            cnt_n = '0;
                            if (halves[h].ev_e) begin
                                got_n = 1'b1;
                                cap_n = '0;
                            end
                        end
                    end
                    FA_MEAS: begin
                        if (halves[h].ref_e) begin
                            st_n  = FA_DONE;
                            res_n = got_n ? cap_n : CNT_MAX;
                        end else begin
                            if (cnt_n != CNT_MAX) begin
                                cnt_n = cnt_n + 1'b1;
                            end
                            if (halves[h].ev_e && !got_n) begin
                                got_n = 1'b1;
                                cap_n = cnt_n;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FA_IDLE;
            arm_q   <= '0;
            cnt_q   <= '0;
            cap_q   <= '0;
            res_q   <= '0;
            got_q   <= 1'b0;
            start_p <= 1'b0;
        end else begin
            st_q    <= st_n;
            arm_q   <= arm_n;
            cnt_q   <= cnt_n;
            cap_q   <= cap_n;
            res_q   <= res_n;
            got_q   <= got_n;
            start_p <= start_s;
        end
    end

    assign done_o   = (st_q == FA_DONE);
    assign result_o = res_q;

    AST_ARMED_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (st_q == FA_SYNC && $past(st_q) == FA_IDLE) |-> $past(arm_q) == ARM_FULL); // R2
    AST_DONE_FROM_MEAS: assert property (@(posedge clk) disable iff (rst)
        (st_q == FA_DONE && $past(st_q) != FA_DONE) |-> $past(st_q) == FA_MEAS); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q != FA_DONE || $past(st_q) == FA_DONE) |-> $stable(res_q)); // R8
    AST_CLEAR_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
        (st_q == FA_DONE && !start_s) |=> st_q == FA_IDLE); // R8
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((st_q == FA_SYNC || st_q == FA_MEAS) && !start_s) |=> st_q == FA_IDLE); // R9

endmodule

// File: rtl/fa_align_eval.sv
module fa_align_eval
    import fa_eval_pkg::*;
#(
    parameter int RES_WIDTH = RES_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_pulse_i,
    input  logic                 eval_i,
    input  logic                 rise_fmt_i,
    input  logic                 start_i,
    output logic [RES_WIDTH-1:0] result_o,
    output logic                 done_o
);
    logic [1:0]            prev_s, h0_s, h1_s;
    logic                  start_s;
    fa_half_s [HALVES-1:0] halves;

    fa_dual_sampler #(.W(2)) sampler_i (
        .clk    (clk),
        .din    ({eval_i, frame_pulse_i}),
        .prev_q (prev_s),
        .h0_q   (h0_s),
        .h1_q   (h1_s)
    );

    // start bit registered in the same stage as the half-samples
    always_ff @(posedge clk) begin
        if (rst) begin
            start_s <= 1'b0;
        end else begin
            start_s <= start_i;
        end
    end

    fa_edge_find edges_i (
        .rise   (rise_fmt_i),
        .prev_s (prev_s),
        .h0_s   (h0_s),
        .h1_s   (h1_s),
        .halves (halves)
    );

    fa_meas_core #(.RW(RES_WIDTH)) core_i (
        .clk      (clk),
        .rst      (rst),
        .halves   (halves),
        .start_s  (start_s),
        .result_o (result_o),
        .done_o   (done_o)
    );

endmodule

// File: tb/fa_align_eval_tb.sv
module fa_align_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fp = 1'b1;
    logic        ev = 1'b1;
    logic        rise = 1'b0;
    logic        start = 1'b0;
    logic [11:0] result_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int hc = 0;
    int flen = 40;
    int eoff = 5;
    int cyc = 0;
    bit finished = 0;

    // behavioural model state
    int m_st, m_arm, m_cnt, m_cap, m_res, m_got, m_sp;
    int m_pfp, m_pev, m_nfp, m_nev;
    int p_done [2];
    int p_res  [2];

    always #10 clk = ~clk;

    fa_align_eval dut_i (
        .clk           (clk),
        .rst           (rst),
        .frame_pulse_i (fp),
        .eval_i        (ev),
        .rise_fmt_i    (rise),
        .start_i       (start),
        .result_o      (result_o),
        .done_o        (done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    function automatic int edg(input int p, input int c);
        return rise ? int'(p == 0 && c == 1) : int'(p == 1 && c == 0);
    endfunction

    function automatic logic fp_at(input int pos);
        return rise ? (pos < 2) : !(pos < 2);
    endfunction

    function automatic logic ev_at(input int pos);
        logic act;
        act = (eoff >= 0) && (pos >= eoff) && (pos < eoff + 3);
        return rise ? act : !act;
    endfunction

    task automatic model_cycle(input int f, input int e, input int s);
        int rf [2];
        int ef [2];
        rf[0] = edg(m_pfp, m_nfp); rf[1] = edg(m_nfp, f);
        ef[0] = edg(m_pev, m_nev); ef[1] = edg(m_nev, e);
        if (m_st == 0) begin
            if (s != 0) m_arm = 0;
            else for (int h = 0; h < 2; h++) if (rf[h] != 0 && m_arm < 2) m_arm++;
            if (s != 0 && m_sp == 0 && m_armed_prev) begin
                m_st = 1; m_got = 0; m_cnt = 0;
            end
        end else if (s == 0) begin
            m_st = 0; m_arm = 0;
        end else begin
            for (int h = 0; h < 2; h++) begin
                if (m_st == 1) begin
                    if (rf[h] != 0) begin
                        m_st = 2; m_cnt = 0;
                        if (ef[h] != 0) begin m_got = 1; m_cap = 0; end
                    end
                end else if (m_st == 2) begin
                    if (rf[h] != 0) begin
                        m_st = 3; m_res = (m_got != 0) ? m_cap : 4095;
                    end else begin
                        if (m_cnt < 4095) m_cnt++;
                        if (ef[h] != 0 && m_got == 0) begin m_got = 1; m_cap = m_cnt; end
                    end
                end
            end
        end
        m_sp = s; m_pfp = f; m_pev = e;
        m_armed_prev = (m_arm == 2);
    endtask

    bit m_armed_prev;

    // one half-sample: drives the value captured at the next clock edge
    task automatic half_step(input int s);
        logic f, e;
        int pos;
        @(clk);
        #5;
        pos = hc % flen;
        f = fp_at(pos);
        e = ev_at(pos);
        if (clk == 1'b0) begin
            chk(done_o == p_done[1][0], "R3 per-clock done", int'(done_o), p_done[1]);
            chk(int'(result_o) == p_res[1], "R6 per-clock result", int'(result_o), p_res[1]);
            p_done[1] = p_done[0];
            p_res[1]  = p_res[0];
            model_cycle(int'(f), int'(e), s);
            p_done[0] = int'(m_st == 3);
            p_res[0]  = m_res;
        end else begin
            m_nfp = int'(f);
            m_nev = int'(e);
        end
        fp = f; ev = e; start = s[0];
        hc++;
    endtask

    task automatic run(input int n, input int s);
        for (int i = 0; i < n; i++) half_step(s);
    endtask

    task automatic do_reset(input logic fmt);
        rise = fmt;
        fp = !fmt; ev = !fmt; start = 1'b0;
        rst = 1'b1;
        repeat (5) @(posedge clk);
        #5 rst = 1'b0;
        m_st = 0; m_arm = 0; m_cnt = 0; m_cap = 0; m_res = 0; m_got = 0; m_sp = 0;
        m_armed_prev = 0;
        m_pfp = int'(!fmt); m_pev = int'(!fmt); m_nfp = int'(!fmt); m_nev = int'(!fmt);
        p_done[0] = 0; p_done[1] = 0; p_res[0] = 0; p_res[1] = 0;
    endtask

    task automatic measure(input int fl, input int off, input int expv, input string tag);
        flen = fl; eoff = off; hc = 0;
        run(2 * fl + 4, 0);
        run(3 * fl + 8, 1);
        chk(done_o == 1'b1, {tag, " done after measurement"}, int'(done_o), 1);
        chk(int'(result_o) == expv, {tag, " measured lag"}, int'(result_o), expv);
        run(2 * fl, 1);
        chk(done_o == 1'b1, "R8 done held while start high", int'(done_o), 1);
        chk(int'(result_o) == expv, "R8 result held while start high", int'(result_o), expv);
        run(6, 0);
        chk(done_o == 1'b0, "R8 done cleared by start low", int'(done_o), 0);
        chk(int'(result_o) == expv, "R8 result kept after clear", int'(result_o), expv);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        chk(result_o == 12'd0, "R1 reset result", int'(result_o), 0);
        @(posedge clk);
        #5;

        // R2: start raised without a full low frame
        flen = 40; eoff = 5; hc = 0;
        run(4, 0);
        run(130, 1);
        chk(done_o == 1'b0, "R2 unarmed start ignored", int'(done_o), 0);
        run(2, 0);

        // R4 falling-edge format, R6 lag values incl. zero and odd
        measure(40, 5, 5, "R4");
        measure(40, 0, 0, "R6 zero lag");
        measure(40, 7, 7, "R6 odd lag");
        measure(40, 15, 15, "R6 7.5 clock lag");
        measure(40, -1, 4095, "R7 no evaluation edge");

        // R10: immediate re-raise after clear is ignored
        run(4, 0);
        run(130, 1);
        chk(done_o == 1'b0, "R10 re-raise without rearm", int'(done_o), 0);
        run(2, 0);

        // R9: abort mid-frame, then no rearm
        flen = 40; eoff = 5; hc = 0;
        run(84, 0);
        run(50, 1);
        run(4, 0);
        chk(done_o == 1'b0, "R9 abort no done", int'(done_o), 0);
        run(130, 1);
        chk(done_o == 1'b0, "R9 abort then unarmed start", int'(done_o), 0);
        run(2, 0);
        measure(40, 3, 3, "R9 recovery");

        // R5 rising-edge format
        do_reset(1'b1);
        #0;
        @(posedge clk);
        #5;
        measure(40, 9, 9, "R5");
        measure(40, 1, 1, "R5 one half lag");

        // R7 saturation in a long frame
        measure(5000, 4500, 4095, "R7 saturation");

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule